// File: doc/BRIEF.md
# Four-Lane Seeded Self-Synchronous Scrambler and Descrambler

This block whitens the 64-bit payload of every block on four parallel lanes of a 64b/66b-style link. The 2-bit sync header beside each payload is carried through untouched. Every lane uses the same self-synchronous polynomial x^58 + x^39 + 1. Each lane starts from a different point on the zero-input sequence of that polynomial, so the lanes carry decorrelated bit streams. A matching descrambler path, seeded the same way, restores the payloads on the receive side.

After reset, a seed generator walks the zero-input sequence one whole block (66 bit steps) per clock. It captures the starting state of each lane as it passes that lane's offset. Once every seed is in place, both paths take in data. A per-lane marker flag lets a fixed pattern, such as an alignment marker, pass through unchanged without moving that lane's state. Each path has a register stage of one cycle.

Top module: `mls_top`

## Requirements
- R1: Transmit bit i of an accepted payload (bit 0 goes first on the line) equals the input bit XOR the scrambled bits sent 39 and 58 bit times earlier on the same lane. The history carries across consecutive accepted blocks.
- R2: An accepted block appears one clock later with valid high, and its 2-bit header is equal to the input header on both the transmit and receive paths.
- R3: Lane 0 starts from the all-ones history. Lane k starts from the history reached after k x 8191 x 66 zero-input steps from all-ones, which is visible as the scrambled image of an all-zero payload.
- R4: seed_ready_o rises exactly (LANES-1) x 8191 + 1 clocks after reset release and then stays high. Valid inputs before that produce no output valid and leave no trace in the lane state.
- R5: A block flagged as marker leaves the lane unchanged in both payload and header, and the lane's history is not advanced by it.
- R6: The receive path, fed with the transmit output of the same lane, returns the original payloads, marker blocks included.
- R7: One received bit flipped at payload bit 0 corrupts descrambled bits 0, 39 and 58 of that block only. The next block on that lane is error-free.
- R8: Lanes are independent. A lane whose valid is low produces no output valid, and its history does not move.
- R9: During reset all valid outputs, seed_ready_o, headers and payload outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seed_ready_o | output | 1 | Lane seeds loaded; blocks are accepted from now on |
| tx_valid_i | input | 4 | Per-lane block valid, transmit side |
| tx_mark_i | input | 4 | Per-lane marker bypass flag, transmit side |
| tx_hdr_i | input | 8 | Per-lane sync headers, lane l at bits 2l+1:2l |
| tx_data_i | input | 256 | Per-lane payloads, lane l at bits 64l+63:64l |
| tx_valid_o | output | 4 | Per-lane scrambled block valid |
| tx_hdr_o | output | 8 | Per-lane headers, unchanged |
| tx_data_o | output | 256 | Per-lane scrambled payloads |
| rx_valid_i | input | 4 | Per-lane block valid, receive side |
| rx_mark_i | input | 4 | Per-lane marker bypass flag, receive side |
| rx_hdr_i | input | 8 | Per-lane received headers |
| rx_data_i | input | 256 | Per-lane received scrambled payloads |
| rx_valid_o | output | 4 | Per-lane descrambled block valid |
| rx_hdr_o | output | 8 | Per-lane headers, unchanged |
| rx_data_o | output | 256 | Per-lane descrambled payloads |

## Verification
On every cycle, the in-line properties check that the header follows an accepted block one cycle later. They also check that a marker block comes out verbatim with the lane history frozen, that nothing is emitted while the seeds are still being built, and that the ready flag never falls once set. The numeric content of the scrambled stream can only be shown by the bench scenarios: the seed offsets through all-zero payloads, the tap positions, lane independence under partial valid masks, inversion through the loopback, and the confined three-bit error spread after a flipped received bit. The bench compares these against its own bit-serial model.

// File: rtl/mls_pkg.sv
package mls_pkg;

   // direction of a lane instance: feedback taken from output or from input bits
   typedef enum logic {
      DIR_TX = 1'b0,
      DIR_RX = 1'b1
   } scr_dir_e;

   localparam int unsigned POLY_TAP_NEAR = 39;
   localparam int unsigned POLY_TAP_FAR  = 58;
   localparam int unsigned STRIDE_BLOCKS = 8191;
   localparam int unsigned PAYLOAD_BITS  = 64;
   localparam int unsigned SYNC_BITS     = 2;

endpackage

// File: rtl/mls_seed_gen.sv
module mls_seed_gen #(
   parameter int unsigned LANES     = 4,
   parameter int unsigned STATE_W   = mls_pkg::POLY_TAP_FAR,
   parameter int unsigned TAP_NEAR  = mls_pkg::POLY_TAP_NEAR,
   parameter int unsigned STRIDE    = mls_pkg::STRIDE_BLOCKS,
   parameter int unsigned STEP_BITS = 66
) (
   input  logic                              clk_i,
   input  logic                              rst_ni,
   output logic [LANES-1:0][STATE_W-1:0]     seeds_o,
   output logic                              done_o
);

   localparam int unsigned CNT_W = $clog2(STRIDE + 1);
   localparam int unsigned IDX_W = (LANES > 2) ? $clog2(LANES) : 1;

   if (LANES < 2) begin : g_bad_lanes
      $error("mls_seed_gen needs at least two lanes");
   end
   if (TAP_NEAR >= STATE_W) begin : g_bad_taps
      $error("near tap must be below the state width");
   end
   if (STRIDE < 1 || STEP_BITS < 1) begin : g_bad_stride
      $error("stride and step size must be positive");
   end

   logic [STATE_W-1:0]              walk_q;
   logic [STATE_W-1:0]              walk_nx;
   logic [STATE_W-1:0]              walk_tmp;
   logic [CNT_W-1:0]                cnt_q;
   logic [IDX_W-1:0]                idx_q;
   logic                            done_q;
   logic [LANES-1:0][STATE_W-1:0]   seed_q;

   // one block worth of zero-input steps per clock
   always_comb begin
      walk_tmp = walk_q;
      for (int b = 0; b < int'(STEP_BITS); b++) begin
         walk_tmp = {walk_tmp[STATE_W-2:0], walk_tmp[TAP_NEAR-1] ^ walk_tmp[STATE_W-1]};
      end
      walk_nx = walk_tmp;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         walk_q <= '1;
         cnt_q  <= '0;
         idx_q  <= IDX_W'(1);
         done_q <= 1'b0;
         seed_q <= '1;
      end else if (!done_q) begin
         walk_q <= walk_nx;
         if (cnt_q == CNT_W'(STRIDE - 1)) begin
            cnt_q         <= '0;
            seed_q[idx_q] <= walk_nx;
            idx_q         <= idx_q + IDX_W'(1);
            if (idx_q == IDX_W'(LANES - 1)) begin
               done_q <= 1'b1;
            end
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign seeds_o = seed_q;
   assign done_o  = done_q;

   // R4
   done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |=> done_q);

   // R4
   walk_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |=> $stable(walk_q));

endmodule

// File: rtl/mls_lane.sv
module mls_lane #(
   parameter mls_pkg::scr_dir_e DIR     = mls_pkg::DIR_TX,
   parameter int unsigned       DATA_W  = mls_pkg::PAYLOAD_BITS,
   parameter int unsigned       HDR_W   = mls_pkg::SYNC_BITS,
   parameter int unsigned       TAP_A   = mls_pkg::POLY_TAP_NEAR,
   parameter int unsigned       TAP_B   = mls_pkg::POLY_TAP_FAR
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_i,
   input  logic [TAP_B-1:0]  seed_i,
   input  logic              valid_i,
   input  logic              mark_i,
   input  logic [HDR_W-1:0]  hdr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              valid_o,
   output logic [HDR_W-1:0]  hdr_o,
   output logic [DATA_W-1:0] data_o
);

   if (TAP_A == 0 || TAP_A >= TAP_B) begin : g_bad_taps
      $error("mls_lane taps must satisfy 0 < TAP_A < TAP_B");
   end
   if (DATA_W < 1 || HDR_W < 1) begin : g_bad_width
      $error("mls_lane widths must be positive");
   end

   logic [TAP_B-1:0]  hist_q;
   logic [TAP_B-1:0]  hist_nx;
   logic [TAP_B-1:0]  hist_tmp;
   logic [DATA_W-1:0] mix;
   logic              take;

   assign take = valid_i & run_i;

   // history bit k holds the line bit sent k+1 bit times ago
   if (DIR == mls_pkg::DIR_RX) begin : g_rx
      always_comb begin
         hist_tmp = hist_q;
         mix      = '0;
         for (int i = 0; i < int'(DATA_W); i++) begin
            mix[i]   = data_i[i] ^ hist_tmp[TAP_A-1] ^ hist_tmp[TAP_B-1];
            hist_tmp = {hist_tmp[TAP_B-2:0], data_i[i]};
         end
         hist_nx = hist_tmp;
      end
   end else begin : g_tx
      always_comb begin
         hist_tmp = hist_q;
         mix      = '0;
         for (int i = 0; i < int'(DATA_W); i++) begin
            mix[i]   = data_i[i] ^ hist_tmp[TAP_A-1] ^ hist_tmp[TAP_B-1];
            hist_tmp = {hist_tmp[TAP_B-2:0], mix[i]};
         end
         hist_nx = hist_tmp;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hist_q  <= '1;
         valid_o <= 1'b0;
         hdr_o   <= '0;
         data_o  <= '0;
      end else begin
         valid_o <= take;
         if (take) begin
            hdr_o  <= hdr_i;
            data_o <= mark_i ? data_i : mix;
         end
         if (!run_i) begin
            hist_q <= seed_i;
         end else if (take && !mark_i) begin
            hist_q <= hist_nx;
         end
      end
   end

   // R5
   mark_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take && mark_i) |=> (data_o == $past(data_i) && hist_q == $past(hist_q)));

   // R2
   hdr_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take |=> (valid_o && hdr_o == $past(hdr_i)));

   // R4
   idle_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> !valid_o);

   // R8
   hold_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && !valid_i) |=> (!valid_o && $stable(hist_q)));

endmodule

// File: rtl/mls_top.sv
module mls_top #(
   parameter int unsigned LANES  = 4,
   parameter int unsigned DATA_W = mls_pkg::PAYLOAD_BITS,
   parameter int unsigned HDR_W  = mls_pkg::SYNC_BITS,
   parameter int unsigned TAP_A  = mls_pkg::POLY_TAP_NEAR,
   parameter int unsigned TAP_B  = mls_pkg::POLY_TAP_FAR,
   parameter int unsigned STRIDE = mls_pkg::STRIDE_BLOCKS
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   output logic                      seed_ready_o,
   input  logic [LANES-1:0]          tx_valid_i,
   input  logic [LANES-1:0]          tx_mark_i,
   input  logic [LANES*HDR_W-1:0]    tx_hdr_i,
   input  logic [LANES*DATA_W-1:0]   tx_data_i,
   output logic [LANES-1:0]          tx_valid_o,
   output logic [LANES*HDR_W-1:0]    tx_hdr_o,
   output logic [LANES*DATA_W-1:0]   tx_data_o,
   input  logic [LANES-1:0]          rx_valid_i,
   input  logic [LANES-1:0]          rx_mark_i,
   input  logic [LANES*HDR_W-1:0]    rx_hdr_i,
   input  logic [LANES*DATA_W-1:0]   rx_data_i,
   output logic [LANES-1:0]          rx_valid_o,
   output logic [LANES*HDR_W-1:0]    rx_hdr_o,
   output logic [LANES*DATA_W-1:0]   rx_data_o
);

   localparam int unsigned BLOCK_W = DATA_W + HDR_W;

   logic [LANES-1:0][TAP_B-1:0] seeds;
   logic                        seeds_done;
   logic                        run_q;

   mls_seed_gen #(
      .LANES     (LANES),
      .STATE_W   (TAP_B),
      .TAP_NEAR  (TAP_A),
      .STRIDE    (STRIDE),
      .STEP_BITS (BLOCK_W)
   ) i_seed_gen (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .seeds_o (seeds),
      .done_o  (seeds_done)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q <= 1'b0;
      end else begin
         run_q <= seeds_done;
      end
   end

   assign seed_ready_o = run_q;

   for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
      mls_lane #(
         .DIR    (mls_pkg::DIR_TX),
         .DATA_W (DATA_W),
         .HDR_W  (HDR_W),
         .TAP_A  (TAP_A),
         .TAP_B  (TAP_B)
      ) i_tx (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .run_i   (run_q),
         .seed_i  (seeds[l]),
         .valid_i (tx_valid_i[l]),
         .mark_i  (tx_mark_i[l]),
         .hdr_i   (tx_hdr_i[l*HDR_W +: HDR_W]),
         .data_i  (tx_data_i[l*DATA_W +: DATA_W]),
         .valid_o (tx_valid_o[l]),
         .hdr_o   (tx_hdr_o[l*HDR_W +: HDR_W]),
         .data_o  (tx_data_o[l*DATA_W +: DATA_W])
      );

      mls_lane #(
         .DIR    (mls_pkg::DIR_RX),
         .DATA_W (DATA_W),
         .HDR_W  (HDR_W),
         .TAP_A  (TAP_A),
         .TAP_B  (TAP_B)
      ) i_rx (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .run_i   (run_q),
         .seed_i  (seeds[l]),
         .valid_i (rx_valid_i[l]),
         .mark_i  (rx_mark_i[l]),
         .hdr_i   (rx_hdr_i[l*HDR_W +: HDR_W]),
         .data_i  (rx_data_i[l*DATA_W +: DATA_W]),
         .valid_o (rx_valid_o[l]),
         .hdr_o   (rx_hdr_o[l*HDR_W +: HDR_W]),
         .data_o  (rx_data_o[l*DATA_W +: DATA_W])
      );
   end

   // R4
   ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seed_ready_o |=> seed_ready_o);

   // R4
   ready_after_seeds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(seed_ready_o) |-> $past(seeds_done));

endmodule

// File: tb/test_mls_top.sv
module test_mls_top;

   localparam int L      = 4;
   localparam int DW     = 64;
   localparam int HW     = 2;
   localparam int STRIDE = 8191;
   localparam int BLK    = 66;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           seed_ready;
   logic [L-1:0]   tx_valid_i = '0, tx_mark_i = '0;
   logic [L*HW-1:0] tx_hdr_i = '0;
   logic [L*DW-1:0] tx_data_i = '0;
   logic [L-1:0]   tx_valid_o;
   logic [L*HW-1:0] tx_hdr_o;
   logic [L*DW-1:0] tx_data_o;
   logic [L-1:0]   rx_valid_i, rx_mark_i = '0;
   logic [L*HW-1:0] rx_hdr_i;
   logic [L*DW-1:0] rx_data_i;
   logic [L*DW-1:0] rx_err = '0;
   logic [L-1:0]   rx_valid_o;
   logic [L*HW-1:0] rx_hdr_o;
   logic [L*DW-1:0] rx_data_o;

   always #5 clk = ~clk;

   assign rx_valid_i = tx_valid_o;
   assign rx_hdr_i   = tx_hdr_o;
   assign rx_data_i  = tx_data_o ^ rx_err;

   mls_top i_mls_top (
      .clk_i(clk), .rst_ni(rst_n), .seed_ready_o(seed_ready),
      .tx_valid_i(tx_valid_i), .tx_mark_i(tx_mark_i), .tx_hdr_i(tx_hdr_i), .tx_data_i(tx_data_i),
      .tx_valid_o(tx_valid_o), .tx_hdr_o(tx_hdr_o), .tx_data_o(tx_data_o),
      .rx_valid_i(rx_valid_i), .rx_mark_i(rx_mark_i), .rx_hdr_i(rx_hdr_i), .rx_data_i(rx_data_i),
      .rx_valid_o(rx_valid_o), .rx_hdr_o(rx_hdr_o), .rx_data_o(rx_data_o)
   );

   typedef struct {
      int          due;
      bit          is_rx;
      logic [3:0]  mask;
      logic [255:0] d;
      logic [7:0]  h;
      string       tag;
   } item_t;

   item_t       sb[$];
   int          cyc = 0;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          ready_seen = 1'b0;
   logic [57:0] tx_st [L];

   logic [3:0]   pend_mask = '0, pend_mark = '0;
   logic [255:0] pend_plain = '0, pend_err = '0;
   logic [7:0]   pend_hdr = '0;
   string        pend_tag = "R6";

   always @(posedge clk) cyc++;

   task automatic check(input string tag, input logic [255:0] got, input logic [255:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   // bit-serial reference: line bit = data XOR bits sent 39 and 58 earlier
   function automatic logic [63:0] ref_scr(inout logic [57:0] s, input logic [63:0] d);
      logic [63:0] o;
      for (int i = 0; i < 64; i++) begin
         o[i] = d[i] ^ s[38] ^ s[57];
         s = {s[56:0], o[i]};
      end
      return o;
   endfunction

   // monitor: compare outputs against the scoreboard
   initial begin
      forever begin
         @(posedge clk);
         #1;
         while (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            logic [255:0] gd;
            logic [7:0]   gh;
            logic [3:0]   gv;
            it = sb.pop_front();
            gv = it.is_rx ? rx_valid_o : tx_valid_o;
            gd = it.is_rx ? rx_data_o : tx_data_o;
            gh = it.is_rx ? rx_hdr_o : tx_hdr_o;
            check({it.tag, it.is_rx ? " rx valid" : " tx valid"}, 256'(gv), 256'(it.mask));
            for (int l = 0; l < L; l++) begin
               if (it.mask[l]) begin
                  check({it.tag, it.is_rx ? " rx data" : " tx data"}, 256'(gd[l*64 +: 64]), 256'(it.d[l*64 +: 64]));
                  check({it.tag, " hdr R2"}, 256'(gh[l*2 +: 2]), 256'(it.h[l*2 +: 2]));
               end
            end
         end
      end
   end

   // driver: called at a falling edge, returns at the next falling edge
   task automatic step(input string tag, input logic [3:0] v, input logic [3:0] m,
                       input logic [255:0] d, input logic [7:0] h, input logic [255:0] e);
      item_t rx_it, tx_it;
      logic [3:0] acc;
      // receive side of the block sent on the previous call
      rx_err    = pend_err;
      rx_mark_i = pend_mark;
      rx_it.due = cyc + 1;
      rx_it.is_rx = 1'b1;
      rx_it.mask = pend_mask;
      rx_it.h = pend_hdr;
      rx_it.tag = pend_tag;
      rx_it.d = '0;
      for (int l = 0; l < L; l++) begin
         logic [63:0] p, x;
         p = pend_plain[l*64 +: 64];
         x = pend_err[l*64 +: 64];
         rx_it.d[l*64 +: 64] = p ^ x ^ (x << 39) ^ (x << 58);
      end
      sb.push_back(rx_it);
      // transmit side of this block
      tx_valid_i = v;
      tx_mark_i  = m;
      tx_data_i  = d;
      tx_hdr_i   = h;
      acc = v & {4{ready_seen}};
      tx_it.due = cyc + 1;
      tx_it.is_rx = 1'b0;
      tx_it.mask = acc;
      tx_it.h = h;
      tx_it.tag = tag;
      tx_it.d = '0;
      for (int l = 0; l < L; l++) begin
         if (acc[l]) begin
            if (m[l]) tx_it.d[l*64 +: 64] = d[l*64 +: 64];
            else      tx_it.d[l*64 +: 64] = ref_scr(tx_st[l], d[l*64 +: 64]);
         end
      end
      sb.push_back(tx_it);
      pend_mask  = acc;
      pend_mark  = m & acc;
      pend_plain = d;
      pend_hdr   = h;
      pend_err   = e;
      pend_tag   = (e != '0) ? "R7" : ((m != 0) ? "R5/R6" : "R6");
      @(negedge clk);
   endtask

   function automatic logic [255:0] rnd256();
      return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
   endfunction

   task automatic finish_run();
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired got hang exp completion");
      finish_run();
   end

   initial begin
      int rel;
      logic [57:0] s;
      // reference seeds from zero-input stepping (R3)
      s = '1;
      for (int l = 0; l < L; l++) begin
         tx_st[l] = s;
         for (int k = 0; k < STRIDE * BLK; k++) s = {s[56:0], s[38] ^ s[57]};
      end

      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 ready", 256'(seed_ready), 256'(0));
      check("R9 valids", 256'({tx_valid_o, rx_valid_o}), 256'(0));
      check("R9 data", tx_data_o | rx_data_o, '0);
      check("R9 hdr", 256'({tx_hdr_o, rx_hdr_o}), 256'(0));
      rst_n = 1'b1;
      rel = cyc;

      // R4: blocks offered before seeds are ready are dropped
      step("R4", 4'hF, 4'h0, rnd256(), 8'h55, '0);
      step("R4", 4'hF, 4'h0, rnd256(), 8'hAA, '0);
      step("R4", 4'h0, 4'h0, '0, 8'h00, '0);
      step("R4", 4'h0, 4'h0, '0, 8'h00, '0);
      check("R4 not ready early", 256'(seed_ready), 256'(0));
      while (!seed_ready) @(negedge clk);
      check("R4 ready latency", 256'(cyc - rel), 256'(3 * STRIDE + 1));
      ready_seen = 1'b1;

      // R3: zero payloads expose each lane's seed; R1 history spans blocks
      step("R3", 4'hF, 4'h0, '0, 8'b01_10_01_10, '0);
      step("R3", 4'hF, 4'h0, '0, 8'b10_01_10_01, '0);
      // R1: varied payloads, all lanes
      for (int k = 0; k < 6; k++) step("R1", 4'hF, 4'h0, rnd256(), 8'($urandom), '0);
      step("R1", 4'hF, 4'h0, {4{64'hFFFF_FFFF_FFFF_FFFF}}, 8'hFF, '0);
      step("R1", 4'hF, 4'h0, {4{64'h8000_0000_0000_0001}}, 8'h99, '0);
      // R8: partial valid masks
      step("R8", 4'b0101, 4'h0, rnd256(), 8'h66, '0);
      step("R8", 4'b1010, 4'h0, rnd256(), 8'h5A, '0);
      step("R8", 4'b0001, 4'h0, rnd256(), 8'hA5, '0);
      step("R8", 4'hF, 4'h0, rnd256(), 8'h3C, '0);
      // R5: markers on lanes 1 and 3 must not move their history
      step("R5", 4'hF, 4'b1010, rnd256(), 8'hC3, '0);
      step("R5", 4'hF, 4'b1010, rnd256(), 8'h0F, '0);
      step("R5", 4'hF, 4'h0, rnd256(), 8'hF0, '0);
      step("R5", 4'hF, 4'b0001, rnd256(), 8'h12, '0);
      step("R5", 4'hF, 4'h0, rnd256(), 8'h21, '0);
      // R7: flip received payload bit 0 of lane 2
      step("R7", 4'hF, 4'h0, rnd256(), 8'h44, {64'h0, 64'h1, 64'h0, 64'h0});
      step("R7", 4'hF, 4'h0, rnd256(), 8'h77, '0);
      step("R6", 4'hF, 4'h0, rnd256(), 8'h88, '0);
      // flush
      step("R6", 4'h0, 4'h0, '0, 8'h00, '0);
      step("R6", 4'h0, 4'h0, '0, 8'h00, '0);
      repeat (3) @(negedge clk);
      check("R6 scoreboard drained", 256'(sb.size()), 256'(0));
      finish_run();
   end

endmodule